// File: doc/BRIEF.md
# Paged EEPROM Write-Buffer Controller

This block is the write side of a byte-wide parallel non-volatile memory model. It runs on a system clock and samples active-low chip-enable, write-enable and output-enable once per cycle. Each host byte write is staged in a page buffer that holds one full page. Bytes may arrive in any order, and a later write to the same position replaces the earlier one. All bytes in one load window must target the same page. A write to any other page is dropped and sets a sticky error flag.

The load window stays open while writes keep arriving. It closes once a run of write-free cycles reaches a parameterised timeout. At that point the controller commits the whole page to the storage array in one cycle. Every position that was not loaded in the window is written as FFh. A busy output then stays high for a parameterised number of cycles, and write cycles during that time are ignored. A combinational read port returns array contents so that written data can be checked.

The array size is set by parameters. With `PAGE_SEL_W` at 10 it models the full 128K by 8 part. The default is smaller, which keeps elaboration light.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` and `page_err` are 0, the page buffer is empty and the controller is idle.
- R2: A write cycle is active while `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is taken in the first active cycle. The data is the `din` value of the last active cycle. The byte is accepted in the cycle in which the write cycle ends.
- R3: A byte accepted before the timeout expires keeps the current load window open and restarts the idle count. Every byte of that window is committed by a single programming pass.
- R4: A window that was opened at clock edge P, or last reloaded at edge P, starts programming at edge P+`LOAD_TIMEOUT`, provided no write cycle is active during that time. `busy` rises at that edge.
- R5: Programming writes all PAGE_BYTES positions of the window's page together. Unloaded positions become FFh. Other pages keep their contents.
- R6: Bytes may be loaded in any offset order. Address bits [6:0] select the offset and the upper bits select the page. When an offset is written twice in a window, the last value wins.
- R7: `busy` stays high for exactly `PROG_CYCLES` cycles. Write cycles during that time are ignored and do not open a new window.
- R8: A write whose page differs from the page of the window's first byte is ignored. It sets `page_err`, which stays 1 until reset.
- R9: When `ce_n`=0 and `oe_n`=0, `dout_valid`=1 and `dout` equals the array byte at `addr`. Otherwise `dout_valid`=0 and `dout`=0.
- R10: A cycle with `ce_n`=0 and `we_n`=0 but `oe_n`=0 is not a write cycle. It loads nothing and opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | PAGE_OFF_W+PAGE_SEL_W | Byte address: offset in the low bits, page above |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not reading |
| dout_valid | output | 1 | Read data valid; stands in for a driven bus |
| busy | output | 1 | High while a page is being programmed |
| page_err | output | 1 | Sticky flag for a write to the wrong page |

## Verification
The assertions assume that the strobe, address and data inputs are synchronous to `clk` and settle well before each rising edge. They also assume `LOAD_TIMEOUT` of at least 2 and `PROG_CYCLES` of at least 1. The bench meets these conditions by changing every input only on the falling clock edge. It overrides the timing parameters with small values and holds each write cycle for a single active cycle. Where a test depends on timing, it counts falling edges from the point at which a write ends.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pw_state_e;
endpackage

// File: rtl/eeprom_pw_strobe.sv
// Decodes the write-cycle strobes, latches the address on entry and the data on every active cycle.
module eeprom_pw_strobe #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_active,
    output logic              wr_done,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] dat;
    } strobe_s;

    strobe_s s_d, s_q;

    always_comb begin
        wr_active = !ce_n && !we_n && oe_n;
        s_d       = s_q;
        s_d.act   = wr_active;
        if (wr_active && !s_q.act) s_d.adr = addr;
        if (wr_active)             s_d.dat = din;
        wr_done   = s_q.act && !wr_active;
        cap_addr  = s_q.adr;
        cap_data  = s_q.dat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: a completed write cycle is reported once, never twice in a row
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);
endmodule

// File: rtl/eeprom_pw_pagebuf.sv
// Page staging buffer: one byte and one loaded flag per offset.
module eeprom_pw_pagebuf #(
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [OFF_W-1:0]                   wr_off,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               clr,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0]  page_data,
    output logic [(1<<OFF_W)-1:0]              page_valid
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    logic [PAGE_BYTES-1:0][DATA_W-1:0] data_d, data_q;
    logic [PAGE_BYTES-1:0]             valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (clr) begin
            valid_d = '0;
        end else if (wr_en) begin
            valid_d[wr_off] = 1'b1;
            data_d[wr_off]  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign page_data  = data_q;
    assign page_valid = valid_q;

    // R6: loaded flags only accumulate inside a window
    a_r6_valid_grow: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((valid_q & $past(valid_q)) == $past(valid_q)));
endmodule

// File: rtl/eeprom_pw_array.sv
// Storage array with a whole-page commit port and an asynchronous read port.
module eeprom_pw_array #(
    parameter int OFF_W  = 7,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               commit,
    input  logic [SEL_W-1:0]                   commit_page,
    input  logic [(1<<OFF_W)-1:0][DATA_W-1:0]  page_data,
    input  logic [(1<<OFF_W)-1:0]              page_valid,
    input  logic [OFF_W+SEL_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]                  rd_data
);
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int DEPTH      = 1 << (OFF_W + SEL_W);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                mem_q[{commit_page, OFF_W'(i)}] <= page_valid[i] ? page_data[i] : '1;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int PAGE_OFF_W   = 7,
    parameter int PAGE_SEL_W   = 4,
    parameter int LOAD_TIMEOUT = 37500,
    parameter int PROG_CYCLES  = 125000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ce_n,
    input  logic                            we_n,
    input  logic                            oe_n,
    input  logic [PAGE_OFF_W+PAGE_SEL_W-1:0] addr,
    input  logic [BYTE_W-1:0]               din,
    output logic [BYTE_W-1:0]               dout,
    output logic                            dout_valid,
    output logic                            busy,
    output logic                            page_err
);
    localparam int ADDR_W     = PAGE_OFF_W + PAGE_SEL_W;
    localparam int PAGE_BYTES = 1 << PAGE_OFF_W;
    localparam int TMR_W      = $clog2(LOAD_TIMEOUT + 1);
    localparam int PRG_W      = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        pw_state_e             st;
        logic [PAGE_SEL_W-1:0] page;
        logic [TMR_W-1:0]      tmr;
        logic [PRG_W-1:0]      prg;
        logic                  err;
    } ctl_s;

    ctl_s q, d;

    logic                              wr_active, wr_done;
    logic [ADDR_W-1:0]                 cap_addr;
    logic [BYTE_W-1:0]                 cap_data;
    logic                              accept, commit;
    logic [PAGE_SEL_W-1:0]             wr_page;
    logic [PAGE_OFF_W-1:0]             wr_off;
    logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_data;
    logic [PAGE_BYTES-1:0]             page_valid;
    logic [BYTE_W-1:0]                 rd_data;

    eeprom_pw_strobe #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_active(wr_active), .wr_done(wr_done),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    always_comb begin
        wr_page = cap_addr[ADDR_W-1:PAGE_OFF_W];
        wr_off  = cap_addr[PAGE_OFF_W-1:0];
        d       = q;
        accept  = 1'b0;
        commit  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (wr_done) begin
                    accept = 1'b1;
                    d.page = wr_page;
                    d.tmr  = '0;
                    d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (wr_done && wr_page == q.page) begin
                    accept = 1'b1;
                    d.tmr  = '0;
                end else begin
                    if (wr_done) d.err = 1'b1;
                    if (!wr_active) begin
                        if (q.tmr == TMR_W'(LOAD_TIMEOUT - 1)) begin
                            commit = 1'b1;
                            d.prg  = '0;
                            d.st   = ST_PROG;
                        end else begin
                            d.tmr = q.tmr + 1'b1;
                        end
                    end
                end
            end
            ST_PROG: begin
                if (q.prg == PRG_W'(PROG_CYCLES - 1)) d.st  = ST_IDLE;
                else                                  d.prg = q.prg + 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, page: '0, tmr: '0, prg: '0, err: 1'b0};
        else        q <= d;
    end

    eeprom_pw_pagebuf #(.OFF_W(PAGE_OFF_W), .DATA_W(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_off(wr_off),
        .wr_data(cap_data), .clr(commit), .page_data(page_data),
        .page_valid(page_valid)
    );

    eeprom_pw_array #(.OFF_W(PAGE_OFF_W), .SEL_W(PAGE_SEL_W), .DATA_W(BYTE_W)) u_array (
        .clk(clk), .commit(commit), .commit_page(q.page),
        .page_data(page_data), .page_valid(page_valid),
        .rd_addr(addr), .rd_data(rd_data)
    );

    assign busy       = (q.st == ST_PROG);
    assign page_err   = q.err;
    assign dout_valid = !ce_n && !oe_n;
    assign dout       = dout_valid ? rd_data : '0;

    // R8: the wrong-page flag never clears on its own
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> page_err);
    // R7: the buffer is already empty for the whole programming pass
    a_r7_buf_empty_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (page_valid == '0));
    // R4: programming starts only from an expired load window
    a_r4_start_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.st == ST_LOAD && q.tmr == TMR_W'(LOAD_TIMEOUT - 1)));
    // R7: busy ends only after the full programming count
    a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(q.prg) == PRG_W'(PROG_CYCLES - 1));
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
    localparam int OFF_W = 7;
    localparam int SEL_W = 4;
    localparam int TO    = 20;
    localparam int PC    = 12;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   ce_n, we_n, oe_n;
    logic [OFF_W+SEL_W-1:0] addr;
    logic [7:0]             din;
    logic [7:0]             dout;
    logic                   dout_valid, busy, page_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    eeprom_page_writer #(
        .PAGE_OFF_W(OFF_W), .PAGE_SEL_W(SEL_W),
        .LOAD_TIMEOUT(TO), .PROG_CYCLES(PC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid),
        .busy(busy), .page_err(page_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [SEL_W-1:0] pg, input logic [OFF_W-1:0] off,
                           input logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = {pg, off}; din = d;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd_byte(input logic [SEL_W-1:0] pg, input logic [OFF_W-1:0] off,
                           output logic [7:0] d);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = {pg, off};
        #1;
        d = dout;
        chk(dout_valid === 1'b1, "R9 read valid", int'(dout_valid), 1);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_prog;
        wait_n(TO + PC + 4);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(page_err === 1'b0, "R1 err after reset", int'(page_err), 0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; #1;
        chk(dout_valid === 1'b0 && dout === 8'h00, "R9 no read with oe high",
            int'({dout_valid, dout}), 0);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        chk(dout_valid === 1'b0, "R9 no read with ce high", int'(dout_valid), 0);
        oe_n = 1'b1;
    endtask

    task automatic t_order_fill;
        logic [7:0] v;
        wr_byte(4'd1, 7'd3, 8'h3C);
        wait_prog();
        wr_byte(4'd2, 7'd5, 8'hA0);
        wr_byte(4'd2, 7'd127, 8'h7F);
        wr_byte(4'd2, 7'd0, 8'h10);
        wr_byte(4'd2, 7'd5, 8'hA5);
        wait_n(TO);
        chk(busy === 1'b0, "R4 busy low before timeout", int'(busy), 0);
        wait_n(1);
        chk(busy === 1'b1, "R4 busy at timeout", int'(busy), 1);
        wait_n(PC - 1);
        chk(busy === 1'b1, "R7 busy last cycle", int'(busy), 1);
        wait_n(1);
        chk(busy === 1'b0, "R7 busy ends", int'(busy), 0);
        for (int i = 0; i < 128; i++) begin
            logic [7:0] e;
            e = (i == 5) ? 8'hA5 : (i == 127) ? 8'h7F : (i == 0) ? 8'h10 : 8'hFF;
            rd_byte(4'd2, 7'(i), v);
            chk(v === e, "R5 R6 page fill", int'(v), int'(e));
        end
        rd_byte(4'd1, 7'd3, v);
        chk(v === 8'h3C, "R5 other page kept", int'(v), 8'h3C);
        rd_byte(4'd1, 7'd4, v);
        chk(v === 8'hFF, "R5 other page fill kept", int'(v), 8'hFF);
    endtask

    task automatic t_window_hold;
        logic [7:0] v;
        wr_byte(4'd8, 7'd1, 8'h81);
        wait_n(TO - 2);
        wr_byte(4'd8, 7'd2, 8'h82);
        chk(busy === 1'b0, "R3 window held open", int'(busy), 0);
        wait_n(TO);
        chk(busy === 1'b0, "R3 timeout restarted", int'(busy), 0);
        wait_n(1);
        chk(busy === 1'b1, "R3 one pass after reload", int'(busy), 1);
        wait_n(PC + 2);
        rd_byte(4'd8, 7'd1, v);
        chk(v === 8'h81, "R3 first byte committed", int'(v), 8'h81);
        rd_byte(4'd8, 7'd2, v);
        chk(v === 8'h82, "R3 second byte committed", int'(v), 8'h82);
    endtask

    task automatic t_capture;
        logic [7:0] v;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = {4'd3, 7'd10}; din = 8'h01;
        @(negedge clk);
        addr = {4'd3, 7'd11}; din = 8'h02;
        @(negedge clk);
        din = 8'h03;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        wait_prog();
        rd_byte(4'd3, 7'd10, v);
        chk(v === 8'h03, "R2 first address last data", int'(v), 8'h03);
        rd_byte(4'd3, 7'd11, v);
        chk(v === 8'hFF, "R2 later address unused", int'(v), 8'hFF);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        wr_byte(4'd6, 7'd0, 8'h66);
        wait_n(TO + 2);
        chk(busy === 1'b1, "R7 busy during test", int'(busy), 1);
        wr_byte(4'd6, 7'd1, 8'h77);
        wr_byte(4'd7, 7'd0, 8'h70);
        wait_n(PC + TO + 5);
        chk(busy === 1'b0, "R7 no window from busy writes", int'(busy), 0);
        rd_byte(4'd6, 7'd1, v);
        chk(v === 8'hFF, "R7 busy write dropped", int'(v), 8'hFF);
        rd_byte(4'd6, 7'd0, v);
        chk(v === 8'h66, "R7 loaded byte kept", int'(v), 8'h66);
    endtask

    task automatic t_oe_low;
        logic [7:0] v;
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = {4'd6, 7'd2}; din = 8'h99;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        wait_n(TO + 3);
        chk(busy === 1'b0, "R10 no window with oe low", int'(busy), 0);
        rd_byte(4'd6, 7'd2, v);
        chk(v === 8'hFF, "R10 byte not written", int'(v), 8'hFF);
    endtask

    task automatic t_mismatch;
        logic [7:0] v;
        wr_byte(4'd5, 7'd9, 8'h55);
        wait_prog();
        chk(page_err === 1'b0, "R8 no error on clean window", int'(page_err), 0);
        wr_byte(4'd4, 7'd1, 8'h11);
        wr_byte(4'd5, 7'd9, 8'hAA);
        wait_n(1);
        chk(page_err === 1'b1, "R8 error raised", int'(page_err), 1);
        wait_prog();
        rd_byte(4'd5, 7'd9, v);
        chk(v === 8'h55, "R8 wrong-page byte dropped", int'(v), 8'h55);
        rd_byte(4'd4, 7'd1, v);
        chk(v === 8'h11, "R8 window page committed", int'(v), 8'h11);
        chk(page_err === 1'b1, "R8 error sticky", int'(page_err), 1);
        @(negedge clk); rst_n = 1'b0;
        wait_n(2); rst_n = 1'b1;
        wait_n(1);
        chk(page_err === 1'b0, "R1 R8 error cleared by reset", int'(page_err), 0);
    endtask

    initial begin
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_order_fill();
        t_window_hold();
        t_capture();
        t_busy_ignore();
        t_oe_low();
        t_mismatch();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule